// File: doc/BRIEF.md
# Variable Pulse Width Frame Receiver

This block receives frames from a single-wire bus that uses variable pulse width coding. The bus input reaches it already synchronised and filtered. The block times every active and passive level with one run-length counter and sorts each width into a window. Inside a frame, each short or long level becomes one data bit. The bits are packed most significant bit first into bytes, and each completed byte is offered on a valid/ready output. When the bus stays passive long enough to mark end of data, the block checks the last byte of the frame against a CRC of all the bytes before it. A longer passive period then reports end of frame.

A configuration input switches all timing windows to the quadruple-rate values. When that input is low, quadruple-rate traffic does not fit the start-of-frame window, so the receiver stays idle and ignores it. A frame may carry any number of bytes, so long block transfers are received in the same way as short messages. Interpreting message content, host registers and interrupts are left to the surrounding logic.

Top module: `vpw_frame_rx`

## Requirements
- R1: After reset, rxValid, sofSeen, eofSeen, crcErr and symErr are all low.
- R2: While idle, only an active level lasting from 163 us up to but not including 239 us (normal-rate timing) starts a frame, and it is reported by a one-cycle sofSeen pulse. Any other active or passive level while idle produces no output.
- R3: Inside a frame, a width from 34 us up to but not including 96 us is short, and a width from 96 us up to but not including 163 us is long. A passive short level and an active long level decode as 0. A passive long level and an active short level decode as 1. The first bit of a frame is the passive level that follows the start pulse. Bits are packed MSB first, and every eighth bit completes a byte.
- R4: Once rxValid is high, it stays high with rxData unchanged until a cycle in which rxReady is high.
- R5: When a passive level inside a frame reaches 163 us with a whole number of bytes received, the CRC is checked. On a mismatch, a one-cycle crcErr pulse is raised and the receiver returns to idle without reporting end of frame.
- R6: The CRC is CRC-8 with polynomial x^8+x^4+x^3+x^2+1, processed MSB first, preset to 0xFF. A frame is good when its last byte equals the bitwise inverse of the CRC over all the bytes before it.
- R7: After a good CRC check, a passive level reaching 239 us gives a one-cycle eofSeen pulse, and the receiver returns to idle.
- R8: Inside a frame, any of the following gives a one-cycle symErr pulse and a return to idle: an active level shorter than 34 us or at least 163 us long, a passive level shorter than 34 us, or end of data reached with a partial byte or with no bytes. crcErr and symErr never pulse in the same cycle.
- R9: With rx4xEn high, every window boundary is a quarter of its normal value, and frames sent at four times the normal rate are decoded in full.
- R10: With rx4xEn low, a frame sent at four times the normal rate produces no start, byte, error or end output.
- R11: There is no limit on frame length. A frame with many data bytes is decoded without any error.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous reset, active low |
| busIn | input | 1 | Synchronised bus level, 1 = active |
| rx4xEn | input | 1 | Select quadruple-rate timing windows |
| rxReady | input | 1 | Consumer accepts rxData this cycle |
| rxData | output | 8 | Received byte |
| rxValid | output | 1 | rxData holds a byte not yet accepted |
| sofSeen | output | 1 | Pulse: start of frame accepted |
| eofSeen | output | 1 | Pulse: end of frame after a good check |
| crcErr | output | 1 | Pulse: CRC mismatch at end of data |
| symErr | output | 1 | Pulse: width or framing violation |

## Verification
The assertions assume that rx4xEn changes only while the bus is idle. They also assume that rxReady is returned within one byte time, so a held byte is never replaced before it is accepted. The stimulus meets both conditions. It changes the rate input only after a full end-of-frame gap, and it holds rxReady low for at most one cycle in five. The start-of-frame check measures the active run at the pins, so it relies on busIn being free of glitches. The stimulus drives only whole, clean level widths.

// File: rtl/vpw_rx_pkg.sv
package vpw_rx_pkg;

  typedef enum logic [2:0] {
    W_NOISE,
    W_SHORT,
    W_LONG,
    W_MID,
    W_EXTRA
  } widthCls_e;

  typedef enum logic [1:0] {
    S_IDLE,
    S_FRAME,
    S_TAIL
  } rxState_e;

  // strobes from control to datapath
  typedef struct packed {
    logic frameInit;
    logic takeBit;
    logic bitVal;
  } dpCtl_t;

  // observations from datapath to control
  typedef struct packed {
    logic      levelEnd;
    logic      endedActive;
    widthCls_e cls;
    logic      eodTick;
    logic      eofTick;
    logic      byteAligned;
    logic      anyByte;
    logic      crcGood;
  } dpStat_t;

  localparam logic [7:0] CRC_POLY = 8'h1D;
  localparam logic [7:0] CRC_INIT = 8'hFF;

  function automatic logic [7:0] crcByte(input logic [7:0] seed, input logic [7:0] din);
    logic [7:0] r;
    r = seed;
    for (int i = 7; i >= 0; i--) begin
      if (r[7] ^ din[i]) r = {r[6:0], 1'b0} ^ CRC_POLY;
      else               r = {r[6:0], 1'b0};
    end
    return r;
  endfunction

endpackage

// File: rtl/vpw_rx_datapath.sv
module vpw_rx_datapath
  import vpw_rx_pkg::*;
#(
  parameter int CYC_PER_US   = 50,
  parameter int SHORT_MIN_US = 34,
  parameter int LONG_MIN_US  = 96,
  parameter int MID_MIN_US   = 163,
  parameter int EOF_MIN_US   = 239
) (
  input  logic       clk,
  input  logic       rstN,
  input  logic       busIn,
  input  logic       rx4xEn,
  input  dpCtl_t     ctl,
  output dpStat_t    stat,
  input  logic       rxReady,
  output logic [7:0] rxData,
  output logic       rxValid
);

  localparam int EOF_N   = EOF_MIN_US * CYC_PER_US;
  localparam int CNT_SAT = EOF_N + 1;
  localparam int CNT_W   = $clog2(CNT_SAT + 1);
  localparam int NUM_LIM = 4;
  localparam int LIM_US [NUM_LIM] = '{SHORT_MIN_US, LONG_MIN_US, MID_MIN_US, EOF_MIN_US};

  logic [CNT_W-1:0] lim [NUM_LIM];

  // one window boundary per entry, normal or quarter value
  generate
    for (genvar k = 0; k < NUM_LIM; k++) begin : g_lim
      localparam int NORM = LIM_US[k] * CYC_PER_US;
      localparam int QUAD = NORM / 4;
      assign lim[k] = rx4xEn ? CNT_W'(QUAD) : CNT_W'(NORM);
    end
  endgenerate

  // level run-length measurement
  logic             busLvl;
  logic [CNT_W-1:0] widthCnt;
  logic             edgeNow;

  assign edgeNow = (busIn != busLvl);

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      busLvl   <= 1'b0;
      widthCnt <= CNT_W'(CNT_SAT);
    end else if (edgeNow) begin
      busLvl   <= busIn;
      widthCnt <= CNT_W'(1);
    end else if (widthCnt != CNT_W'(CNT_SAT)) begin
      widthCnt <= widthCnt + CNT_W'(1);
    end
  end

  widthCls_e clsNow;

  always_comb begin
    if (widthCnt < lim[0])      clsNow = W_NOISE;
    else if (widthCnt < lim[1]) clsNow = W_SHORT;
    else if (widthCnt < lim[2]) clsNow = W_LONG;
    else if (widthCnt < lim[3]) clsNow = W_MID;
    else                        clsNow = W_EXTRA;
  end

  // byte assembly and CRC
  logic [2:0] bitCnt;
  logic [7:0] shiftReg;
  logic [7:0] crcRun;
  logic [7:0] crcPrev;
  logic       anyByte;
  logic [7:0] newByte;
  logic       byteDone;

  assign newByte  = {shiftReg[6:0], ctl.bitVal};
  assign byteDone = ctl.takeBit && (bitCnt == 3'd7);

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      bitCnt   <= 3'd0;
      shiftReg <= 8'h00;
      crcRun   <= CRC_INIT;
      crcPrev  <= CRC_INIT;
      anyByte  <= 1'b0;
    end else if (ctl.frameInit) begin
      bitCnt   <= 3'd0;
      crcRun   <= CRC_INIT;
      crcPrev  <= CRC_INIT;
      anyByte  <= 1'b0;
    end else if (ctl.takeBit) begin
      shiftReg <= newByte;
      bitCnt   <= bitCnt + 3'd1;
      if (byteDone) begin
        crcPrev <= crcRun;
        crcRun  <= crcByte(crcRun, newByte);
        anyByte <= 1'b1;
      end
    end
  end

  // single holding register toward the consumer
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      rxData  <= 8'h00;
      rxValid <= 1'b0;
    end else if (byteDone) begin
      rxData  <= newByte;
      rxValid <= 1'b1;
    end else if (rxReady) begin
      rxValid <= 1'b0;
    end
  end

  always_comb begin
    stat.levelEnd    = edgeNow;
    stat.endedActive = busLvl;
    stat.cls         = clsNow;
    stat.eodTick     = !edgeNow && !busLvl && (widthCnt == lim[2]);
    stat.eofTick     = !edgeNow && !busLvl && (widthCnt == lim[3]);
    stat.byteAligned = (bitCnt == 3'd0);
    stat.anyByte     = anyByte;
    stat.crcGood     = (shiftReg == ~crcPrev);
  end

endmodule

// File: rtl/vpw_rx_control.sv
module vpw_rx_control
  import vpw_rx_pkg::*;
(
  input  logic    clk,
  input  logic    rstN,
  input  dpStat_t stat,
  output dpCtl_t  ctl,
  output logic    sofSeen,
  output logic    eofSeen,
  output logic    crcErr,
  output logic    symErr
);

  rxState_e state, stateNxt;
  logic sofNxt, eofNxt, crcNxt, symNxt;
  logic isBit;

  assign isBit = (stat.cls == W_SHORT) || (stat.cls == W_LONG);

  always_comb begin
    stateNxt = state;
    ctl      = '0;
    sofNxt   = 1'b0;
    eofNxt   = 1'b0;
    crcNxt   = 1'b0;
    symNxt   = 1'b0;
    case (state)
      S_IDLE: begin
        if (stat.levelEnd && stat.endedActive && (stat.cls == W_MID)) begin
          ctl.frameInit = 1'b1;
          sofNxt        = 1'b1;
          stateNxt      = S_FRAME;
        end
      end
      S_FRAME: begin
        if (stat.levelEnd) begin
          if (isBit) begin
            ctl.takeBit = 1'b1;
            ctl.bitVal  = stat.endedActive ? (stat.cls == W_SHORT) : (stat.cls == W_LONG);
          end else begin
            symNxt   = 1'b1;
            stateNxt = S_IDLE;
          end
        end else if (stat.eodTick) begin
          if (!stat.byteAligned || !stat.anyByte) begin
            symNxt   = 1'b1;
            stateNxt = S_IDLE;
          end else if (stat.crcGood) begin
            stateNxt = S_TAIL;
          end else begin
            crcNxt   = 1'b1;
            stateNxt = S_IDLE;
          end
        end
      end
      S_TAIL: begin
        if (stat.eofTick) begin
          eofNxt   = 1'b1;
          stateNxt = S_IDLE;
        end else if (stat.levelEnd) begin
          stateNxt = S_IDLE;
        end
      end
      default: stateNxt = S_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      state   <= S_IDLE;
      sofSeen <= 1'b0;
      eofSeen <= 1'b0;
      crcErr  <= 1'b0;
      symErr  <= 1'b0;
    end else begin
      state   <= stateNxt;
      sofSeen <= sofNxt;
      eofSeen <= eofNxt;
      crcErr  <= crcNxt;
      symErr  <= symNxt;
    end
  end

endmodule

// File: rtl/vpw_frame_rx.sv
module vpw_frame_rx
  import vpw_rx_pkg::*;
#(
  parameter int CYC_PER_US   = 50,
  parameter int SHORT_MIN_US = 34,
  parameter int LONG_MIN_US  = 96,
  parameter int MID_MIN_US   = 163,
  parameter int EOF_MIN_US   = 239
) (
  input  logic       clk,
  input  logic       rstN,
  input  logic       busIn,
  input  logic       rx4xEn,
  input  logic       rxReady,
  output logic [7:0] rxData,
  output logic       rxValid,
  output logic       sofSeen,
  output logic       eofSeen,
  output logic       crcErr,
  output logic       symErr
);

  dpCtl_t  ctl;
  dpStat_t stat;

  vpw_rx_datapath #(
    .CYC_PER_US  (CYC_PER_US),
    .SHORT_MIN_US(SHORT_MIN_US),
    .LONG_MIN_US (LONG_MIN_US),
    .MID_MIN_US  (MID_MIN_US),
    .EOF_MIN_US  (EOF_MIN_US)
  ) u_dp (
    .clk    (clk),
    .rstN   (rstN),
    .busIn  (busIn),
    .rx4xEn (rx4xEn),
    .ctl    (ctl),
    .stat   (stat),
    .rxReady(rxReady),
    .rxData (rxData),
    .rxValid(rxValid)
  );

  vpw_rx_control u_ctl (
    .clk    (clk),
    .rstN   (rstN),
    .stat   (stat),
    .ctl    (ctl),
    .sofSeen(sofSeen),
    .eofSeen(eofSeen),
    .crcErr (crcErr),
    .symErr (symErr)
  );

endmodule

// File: rtl/vpw_rx_checker.sv
module vpw_rx_checker #(
  parameter int CYC_PER_US = 50,
  parameter int MID_MIN_US = 163,
  parameter int EOF_MIN_US = 239
) (
  input logic       clk,
  input logic       rstN,
  input logic       busIn,
  input logic       rx4xEn,
  input logic       rxReady,
  input logic [7:0] rxData,
  input logic       rxValid,
  input logic       sofSeen,
  input logic       eofSeen,
  input logic       crcErr,
  input logic       symErr
);

  localparam int MID_N = MID_MIN_US * CYC_PER_US;
  localparam int EOF_N = EOF_MIN_US * CYC_PER_US;

  int   highCnt;
  logic lastBus;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      highCnt <= 0;
      lastBus <= 1'b0;
    end else begin
      lastBus <= busIn;
      if (busIn) highCnt <= lastBus ? highCnt + 1 : 1;
    end
  end

  // R4
  valid_hold_chk: assert property (@(posedge clk) disable iff (!rstN)
    rxValid && !rxReady |=> rxValid);

  // R4
  data_hold_chk: assert property (@(posedge clk) disable iff (!rstN)
    rxValid && !rxReady |=> $stable(rxData));

  // R8
  err_excl_chk: assert property (@(posedge clk) disable iff (!rstN)
    !(crcErr && symErr));

  // R2
  sof_pulse_chk: assert property (@(posedge clk) disable iff (!rstN)
    sofSeen |=> !sofSeen);

  // R10
  quad_ignore_chk: assert property (@(posedge clk) disable iff (!rstN)
    sofSeen && !rx4xEn |-> (highCnt >= MID_N - 2) && (highCnt <= EOF_N + 2));

  // R7
  eof_passive_chk: assert property (@(posedge clk) disable iff (!rstN)
    eofSeen |-> !busIn);

  // R5
  crc_passive_chk: assert property (@(posedge clk) disable iff (!rstN)
    crcErr |-> !busIn);

endmodule

bind vpw_frame_rx vpw_rx_checker #(
  .CYC_PER_US(CYC_PER_US),
  .MID_MIN_US(MID_MIN_US),
  .EOF_MIN_US(EOF_MIN_US)
) u_chk (
  .clk    (clk),
  .rstN   (rstN),
  .busIn  (busIn),
  .rx4xEn (rx4xEn),
  .rxReady(rxReady),
  .rxData (rxData),
  .rxValid(rxValid),
  .sofSeen(sofSeen),
  .eofSeen(eofSeen),
  .crcErr (crcErr),
  .symErr (symErr)
);

// File: tb/tb_vpw_frame_rx.sv
module tb_vpw_frame_rx;

  localparam int CPU = 4;
  localparam int K_SOF = 1, K_BYTE = 2, K_CRC = 3, K_SYM = 4, K_EOF = 5;

  logic       clk = 1'b0;
  logic       rstN = 1'b0;
  logic       busIn = 1'b0;
  logic       rx4xEn = 1'b0;
  logic       rxReady = 1'b0;
  logic [7:0] rxData;
  logic       rxValid, sofSeen, eofSeen, crcErr, symErr;

  always #10 clk = ~clk;

  vpw_frame_rx #(.CYC_PER_US(CPU)) dut (
    .clk(clk), .rstN(rstN), .busIn(busIn), .rx4xEn(rx4xEn), .rxReady(rxReady),
    .rxData(rxData), .rxValid(rxValid), .sofSeen(sofSeen), .eofSeen(eofSeen),
    .crcErr(crcErr), .symErr(symErr)
  );

  typedef struct {
    int    kind;
    int    data;
    string req;
  } evt_t;

  evt_t  expQ[$];
  int    errors = 0;
  int    checks = 0;
  int    cyc = 0;
  bit    done = 1'b0;
  string curReq = "R2";

  function automatic string kname(int k);
    case (k)
      K_SOF:  return "sof";
      K_BYTE: return "byte";
      K_CRC:  return "crcErr";
      K_SYM:  return "symErr";
      K_EOF:  return "eof";
      default: return "none";
    endcase
  endfunction

  function automatic int crc8(logic [7:0] b[$]);
    int c = 255;
    foreach (b[n]) begin
      for (int i = 7; i >= 0; i--) begin
        int fb = ((c >> 7) ^ (b[n] >> i)) & 1;
        c = (c << 1) & 255;
        if (fb != 0) c = c ^ 29;
      end
    end
    return c ^ 255;
  endfunction

  task automatic expectEvt(int k, int d, string r);
    evt_t e;
    e.kind = k; e.data = d; e.req = r;
    expQ.push_back(e);
  endtask

  task automatic observe(int k, int d);
    evt_t e;
    checks++;
    if (expQ.size() == 0) begin
      errors++;
      $display("FAIL %s: got %s %02h, expected no event", curReq, kname(k), d);
    end else begin
      e = expQ.pop_front();
      if (e.kind != k || (k == K_BYTE && e.data != d)) begin
        errors++;
        $display("FAIL %s: got %s %02h, expected %s %02h", e.req, kname(k), d, kname(e.kind), e.data);
      end
    end
  endtask

  // ready pattern drives first, then the handshake for the coming edge is observed
  always @(negedge clk) begin
    cyc++;
    rxReady = (cyc % 5) != 3;
    if (rstN && !done) begin
      if (sofSeen)            observe(K_SOF, 0);
      if (rxValid && rxReady) observe(K_BYTE, int'(rxData));
      if (crcErr)             observe(K_CRC, 0);
      if (symErr)             observe(K_SYM, 0);
      if (eofSeen)            observe(K_EOF, 0);
    end
  end

  task automatic buildFrame(input logic [7:0] b[$], input int nbits, output int w[$]);
    w = {};
    w.push_back(200);
    for (int i = 0; i < nbits; i++) begin
      logic v = b[i / 8][7 - (i % 8)];
      if (i % 2 == 0) w.push_back(v ? 128 : 64);
      else            w.push_back(v ? 64 : 128);
    end
  endtask

  task automatic play(input int w[$], input bit quad);
    foreach (w[i]) begin
      busIn = (i % 2 == 0);
      repeat (quad ? w[i] : w[i] * CPU) @(negedge clk);
    end
    busIn = 1'b0;
    repeat (quad ? 320 : 320 * CPU) @(negedge clk);
  endtask

  task automatic endCheck(string r);
    checks++;
    if (expQ.size() != 0) begin
      errors++;
      $display("FAIL %s: %0d events still pending, expected 0", r, expQ.size());
    end
    expQ.delete();
  endtask

  task automatic goodFrame(input logic [7:0] d[$], input bit quad, input string r);
    logic [7:0] f[$];
    int w[$];
    f = d;
    f.push_back(8'(crc8(d)));
    curReq = r;
    expectEvt(K_SOF, 0, r);
    foreach (d[i]) expectEvt(K_BYTE, d[i], r);
    expectEvt(K_BYTE, f[f.size() - 1], {r, "/R6"});
    expectEvt(K_EOF, 0, {r, "/R7"});
    buildFrame(f, f.size() * 8, w);
    play(w, quad);
    endCheck(r);
  endtask

  initial begin
    logic [7:0] d[$];
    int w[$];
    repeat (3) @(negedge clk);
    // R1: reset values
    checks++;
    if (rxValid || sofSeen || eofSeen || crcErr || symErr) begin
      errors++;
      $display("FAIL R1: outputs %b%b%b%b%b, expected 00000", rxValid, sofSeen, eofSeen, crcErr, symErr);
    end
    rstN = 1'b1;
    repeat (5) @(negedge clk);

    // R2: stray pulses while idle give nothing
    curReq = "R2";
    play('{100, 50, 300, 60, 20}, 1'b0);
    endCheck("R2");

    // R3 R4 R6 R7: normal-rate frame
    goodFrame('{8'h3C, 8'hA1, 8'h07}, 1'b0, "R3");

    // R10: quad-rate frame ignored while disabled
    curReq = "R10";
    d = '{8'h55, 8'hF0};
    d.push_back(8'(crc8(d)));
    buildFrame(d, 24, w);
    play(w, 1'b1);
    endCheck("R10");
    goodFrame('{8'h81}, 1'b0, "R10");

    // R9: quad-rate frames decoded when enabled
    rx4xEn = 1'b1;
    goodFrame('{8'h12, 8'hFE, 8'h00, 8'h9B}, 1'b1, "R9");
    goodFrame('{8'hC3}, 1'b1, "R9");
    rx4xEn = 1'b0;
    repeat (20) @(negedge clk);

    // R5: bad CRC byte
    curReq = "R5";
    d = '{8'h6D, 8'h11};
    d.push_back(8'(crc8(d) ^ 1));
    expectEvt(K_SOF, 0, "R5"); expectEvt(K_BYTE, 8'h6D, "R5");
    expectEvt(K_BYTE, 8'h11, "R5"); expectEvt(K_BYTE, d[2], "R5");
    expectEvt(K_CRC, 0, "R5");
    buildFrame(d, 24, w);
    play(w, 1'b0);
    endCheck("R5");

    // R8: short active glitch inside a frame
    curReq = "R8";
    expectEvt(K_SOF, 0, "R8"); expectEvt(K_BYTE, 8'h55, "R8"); expectEvt(K_SYM, 0, "R8");
    buildFrame('{8'h55}, 8, w);
    w.push_back(64); w.push_back(20);
    play(w, 1'b0);
    endCheck("R8");

    // R8: over-long active inside a frame
    expectEvt(K_SOF, 0, "R8"); expectEvt(K_BYTE, 8'hE7, "R8"); expectEvt(K_SYM, 0, "R8");
    buildFrame('{8'hE7}, 8, w);
    w.push_back(64); w.push_back(170);
    play(w, 1'b0);
    endCheck("R8");

    // R8: end of data with a partial byte
    expectEvt(K_SOF, 0, "R8"); expectEvt(K_BYTE, 8'hA5, "R8"); expectEvt(K_SYM, 0, "R8");
    buildFrame('{8'hA5, 8'h3C}, 12, w);
    play(w, 1'b0);
    endCheck("R8");

    // R8: end of data with no byte at all
    expectEvt(K_SOF, 0, "R8"); expectEvt(K_SYM, 0, "R8");
    play('{200}, 1'b0);
    endCheck("R8");

    // R11: block frame, many bytes
    d = {};
    for (int i = 0; i < 12; i++) d.push_back(8'((i * 37 + 5) & 255));
    goodFrame(d, 1'b0, "R11");

    done = 1'b1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    repeat (190000) @(posedge clk);
    if (!done) begin
      done = 1'b1;
      errors++;
      checks++;
      $display("FAIL watchdog: run not finished, expected completion");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

endmodule